// File: doc/BRIEF.md
# Ethernet Receive Frame Parser

This block sits after a PCS that hands over one byte per clock together with a control flag. The flag marks special code groups, and a valid flag marks whether any byte is present. A receive state machine finds the packet start group, skips the preamble up to the start frame delimiter, and then walks through the frame. The frame runs from the destination address through the frame check sequence. Every frame byte is passed downstream with a write enable, so that a drop buffer can hold the frame while a filter decides what to do with it. Strobes mark the bytes of the destination address, the source address and the length/type field. This lets a filter pick out those fields without its own byte counter.

While the frame streams in, the block classifies the destination as broadcast and/or group addressed. It sorts the length/type field into a payload length, an EtherType or an invalid value. It runs a CRC-32 over the frame and counts its length. When an end or carrier-extend group arrives, a one-cycle end pulse reports whether the frame is good. A stray control group or a loss of data inside the frame ends it early as bad.

All outputs are registered. A byte sampled at a clock edge shows its effect on the outputs right after that edge.

Top module: `eth_rx_frame_parser`

## Requirements
- R1: While reset is high and right after it, wr_en, all strobes, frame_end, frame_good, dst_bcast, dst_group and lt_kind are zero.
- R2: A control byte 0xFB (rx_k=1) in idle starts a packet. Data bytes 0x55 are skipped. A data byte 0xD5 moves to the frame. Any other data byte, a control byte or rx_valid low before 0xD5 drops the packet, with no write and no end pulse.
- R3: Every data byte after 0xD5 up to the terminator, including the four FCS bytes, is output with wr_en=1 and wr_data equal to the byte, one cycle after it is sampled.
- R4: da_stb is high with frame bytes 0-5, sa_stb with bytes 6-11 and lt_stb with bytes 12-13. At most one strobe is high, and only while wr_en is high.
- R5: dst_bcast=1 when all six destination bytes are 0xFF. dst_group=1 when bit 0 of the first destination byte is 1. Both update together with the write of destination byte 5, hold until the next 0xFB start, and are cleared by it.
- R6: lt_kind, formed from bytes 12 (high) and 13 (low), updates with the write of byte 13 and holds until the next start: 1 for a value of 1500 or less, 2 for 0x0600 or more, 3 for values in between, 0 before the field is seen.
- R7: A control byte 0xFD, or 0xF7, inside the frame ends it. frame_end is high for exactly one cycle, the cycle after that byte, and frame_good is valid with it.
- R8: frame_good requires the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones) over all frame bytes, FCS included, to leave the residue 0xC704DD7B (0xDEBB20E3 in shift-right bit order). The FCS is the inverted CRC of the preceding bytes, sent low byte first.
- R9: frame_good also requires a frame length, counted from the first destination byte through the last FCS byte, of 64 to 1518 bytes inclusive.
- R10: Inside the frame, a control byte other than 0xFD/0xF7, or rx_valid low, gives frame_end=1 with frame_good=0 and returns to idle. Later data bytes are not written.
- R11: Control bytes 0xF7 (or any other byte) received in idle, such as carrier extension after an end, cause no write and no end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_k | input | 1 | High when rx_data is a control code group |
| rx_valid | input | 1 | High when a byte is present |
| wr_en | output | 1 | Frame byte write enable |
| wr_data | output | 8 | Frame byte |
| da_stb | output | 1 | Destination address byte strobe |
| sa_stb | output | 1 | Source address byte strobe |
| lt_stb | output | 1 | Length/type byte strobe |
| dst_bcast | output | 1 | Broadcast destination flag |
| dst_group | output | 1 | Group destination flag |
| lt_kind | output | 2 | Length/type class: 0 unseen, 1 length, 2 type, 3 invalid |
| frame_end | output | 1 | One-cycle end-of-frame pulse |
| frame_good | output | 1 | Frame status, valid with frame_end |

## Verification
Some rules hold on every cycle, and the in-line assertions check those. The end pulse never lasts two cycles, and no write follows it. The field strobes are mutually exclusive and never occur without a write. A broadcast flag always comes with the group flag, and a good status never comes with an out-of-range length. The CRC register and the length/type class stay frozen when not updated. Only the bench scenarios can show the other behaviour: which bytes reach the write port, and the values of the classifications. The same goes for the good/bad outcome at the length limits 63, 64, 1518 and 1519, with corrupted FCS, and for each early-termination path.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_BODY} rx_state_t;

  localparam logic [7:0] K_START = 8'hFB;
  localparam logic [7:0] K_TERM  = 8'hFD;
  localparam logic [7:0] K_EXT   = 8'hF7;
  localparam logic [7:0] B_PRE   = 8'h55;
  localparam logic [7:0] B_SFD   = 8'hD5;

  localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE  = 32'hDEBB20E3;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/eth_rx_crc.sv
module eth_rx_crc
  import eth_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       init,
  input  logic       upd,
  input  logic [7:0] din,
  output logic       crc_ok
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || init) crc_q <= '1;
    else if (upd)    crc_q <= crc_step(crc_q, din);
  end

  assign crc_ok = (crc_q == CRC_RESIDUE);

  // R8: the register only moves on a preset or a frame byte
  p_crc_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!init && !upd) |=> $stable(crc_q));
endmodule

// File: rtl/eth_rx_dacls.sv
module eth_rx_dacls (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [2:0] idx,
  input  logic [7:0] din,
  output logic       bcast,
  output logic       group
);
  localparam logic [2:0] LAST_IDX = 3'd5;
  logic ones_run;
  logic group_pend;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ones_run   <= 1'b0;
      group_pend <= 1'b0;
      bcast      <= 1'b0;
      group      <= 1'b0;
    end else if (en) begin
      if (idx == 3'd0) begin
        ones_run   <= &din;
        group_pend <= din[0];
      end else if (idx == LAST_IDX) begin
        bcast <= ones_run & (&din);
        group <= group_pend;
      end else begin
        ones_run <= ones_run & (&din);
      end
    end
  end

  // R5: an all-ones address always has its group bit set
  p_bcast_group_r5: assert property (@(posedge clk) disable iff (rst)
    bcast |-> group);
endmodule

// File: rtl/eth_rx_ltcls.sv
module eth_rx_ltcls #(
  parameter int MAX_LEN_FIELD = 1500,
  parameter int MIN_TYPE      = 16'h0600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en_hi,
  input  logic       en_lo,
  input  logic [7:0] din,
  output logic [1:0] kind
);
  localparam logic [15:0] LEN_LIM  = 16'(MAX_LEN_FIELD);
  localparam logic [15:0] TYPE_LIM = 16'(MIN_TYPE);
  logic [7:0]  hi_q;
  logic [15:0] val;

  assign val = {hi_q, din};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hi_q <= '0;
      kind <= 2'd0;
    end else begin
      if (en_hi) hi_q <= din;
      if (en_lo) begin
        if (val <= LEN_LIM)       kind <= 2'd1;
        else if (val >= TYPE_LIM) kind <= 2'd2;
        else                      kind <= 2'd3;
      end
    end
  end

  // R6: the class holds between its update and the next start
  p_kind_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en_lo) |=> $stable(kind));
endmodule

// File: rtl/eth_rx_frame_parser.sv
module eth_rx_frame_parser
  import eth_rx_pkg::*;
#(
  parameter int MIN_FRAME     = 64,
  parameter int MAX_FRAME     = 1518,
  parameter int MAX_LEN_FIELD = 1500,
  parameter int MIN_TYPE      = 16'h0600,
  parameter int DA_BYTES      = 6,
  parameter int SA_BYTES      = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] rx_data,
  input  logic       rx_k,
  input  logic       rx_valid,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       da_stb,
  output logic       sa_stb,
  output logic       lt_stb,
  output logic       dst_bcast,
  output logic       dst_group,
  output logic [1:0] lt_kind,
  output logic       frame_end,
  output logic       frame_good
);
  localparam int CNT_W = $clog2(MAX_FRAME + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_FRAME);
  localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAX_FRAME);
  localparam logic [CNT_W-1:0] SA_LO   = CNT_W'(DA_BYTES);
  localparam logic [CNT_W-1:0] LT_LO   = CNT_W'(DA_BYTES + SA_BYTES);
  localparam logic [CNT_W-1:0] LT_HI   = CNT_W'(DA_BYTES + SA_BYTES + 1);

  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             start_hit, take, crc_ok;

  assign start_hit = (state == ST_IDLE) && rx_valid && rx_k && (rx_data == K_START);
  assign take      = (state == ST_BODY) && rx_valid && !rx_k;

  eth_rx_crc u_crc (
    .clk(clk), .rst(rst), .init(start_hit), .upd(take), .din(rx_data), .crc_ok(crc_ok)
  );

  eth_rx_dacls u_da (
    .clk(clk), .rst(rst), .clr(start_hit), .en(take && (cnt < SA_LO)),
    .idx(cnt[2:0]), .din(rx_data), .bcast(dst_bcast), .group(dst_group)
  );

  eth_rx_ltcls #(.MAX_LEN_FIELD(MAX_LEN_FIELD), .MIN_TYPE(MIN_TYPE)) u_lt (
    .clk(clk), .rst(rst), .clr(start_hit),
    .en_hi(take && (cnt == LT_LO)), .en_lo(take && (cnt == LT_HI)),
    .din(rx_data), .kind(lt_kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      wr_en      <= 1'b0;
      wr_data    <= '0;
      da_stb     <= 1'b0;
      sa_stb     <= 1'b0;
      lt_stb     <= 1'b0;
      frame_end  <= 1'b0;
      frame_good <= 1'b0;
    end else begin
      wr_en      <= 1'b0;
      da_stb     <= 1'b0;
      sa_stb     <= 1'b0;
      lt_stb     <= 1'b0;
      frame_end  <= 1'b0;
      frame_good <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_hit) begin
            state <= ST_PRE;
            cnt   <= '0;
          end
        end
        ST_PRE: begin
          if (!rx_valid || rx_k)        state <= ST_IDLE;
          else if (rx_data == B_SFD)    state <= ST_BODY;
          else if (rx_data != B_PRE)    state <= ST_IDLE;
        end
        ST_BODY: begin
          if (take) begin
            wr_en   <= 1'b1;
            wr_data <= rx_data;
            da_stb  <= (cnt < SA_LO);
            sa_stb  <= (cnt >= SA_LO) && (cnt < LT_LO);
            lt_stb  <= (cnt == LT_LO) || (cnt == LT_HI);
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
          end else begin
            frame_end <= 1'b1;
            state     <= ST_IDLE;
            if (rx_valid && ((rx_data == K_TERM) || (rx_data == K_EXT)))
              frame_good <= crc_ok && (cnt >= MIN_C) && (cnt <= MAX_C);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: the end pulse lasts one cycle
  p_end_single_r7: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);
  // R10: nothing is written once a frame has ended
  p_no_wr_after_end_r10: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !wr_en);
  // R9: a good status never goes with an out-of-range length
  p_good_len_r9: assert property (@(posedge clk) disable iff (rst)
    (frame_end && frame_good) |-> ((cnt >= MIN_C) && (cnt <= MAX_C)));
  // R4: strobes are exclusive and ride on a write
  p_stb_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({da_stb, sa_stb, lt_stb}));
  p_stb_wr_r4: assert property (@(posedge clk) disable iff (rst)
    (da_stb || sa_stb || lt_stb) |-> wr_en);
endmodule

// File: tb/eth_rx_frame_parser_tb.sv
module eth_rx_frame_parser_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 1234;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] rx_data = 8'h00;
  logic rx_k = 1'b0;
  logic rx_valid = 1'b0;
  logic wr_en, da_stb, sa_stb, lt_stb, dst_bcast, dst_group, frame_end, frame_good;
  logic [7:0] wr_data;
  logic [1:0] lt_kind;

  int total = 0;
  int bad = 0;
  int wr_seen = 0;
  int end_seen = 0;
  bit done = 1'b0;
  logic [7:0] frm [0:1599];

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_frame_parser dut_i (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_k(rx_k), .rx_valid(rx_valid),
    .wr_en(wr_en), .wr_data(wr_data), .da_stb(da_stb), .sa_stb(sa_stb), .lt_stb(lt_stb),
    .dst_bcast(dst_bcast), .dst_group(dst_group), .lt_kind(lt_kind),
    .frame_end(frame_end), .frame_good(frame_good)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic k, input logic v);
    @(negedge clk);
    rx_data = d; rx_k = k; rx_valid = v;
    @(posedge clk);
    #1;
    if (wr_en) wr_seen++;
    if (frame_end) end_seen++;
  endtask

  function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic int lt_class(input logic [15:0] v);
    if (v <= 16'd1500) return 1;
    if (v >= 16'h0600) return 2;
    return 3;
  endfunction

  task automatic build(input int n, input logic [47:0] da, input logic [15:0] lt);
    logic [31:0] c;
    for (int i = 0; i < 6; i++) frm[i] = da[47-8*i -: 8];
    for (int i = 6; i < 12; i++) frm[i] = 8'($urandom);
    frm[12] = lt[15:8];
    frm[13] = lt[7:0];
    for (int i = 14; i < n - 4; i++) frm[i] = 8'($urandom);
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n - 4; i++) c = crc_b(c, frm[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) frm[n-4+i] = c[8*i +: 8];
  endtask

  task automatic head();
    send(8'hFB, 1'b1, 1'b1);
    for (int i = 0; i < 7; i++) send(8'h55, 1'b0, 1'b1);
    send(8'hD5, 1'b0, 1'b1);
  endtask

  // sends frm[0..n-1] and checks writes, strobes, classes and status
  task automatic run_frame(input int n, input logic [7:0] term, input bit corrupt,
                           input logic [47:0] da, input logic [15:0] lt);
    int wr_err, stb_err;
    bit exp_good;
    wr_err = 0; stb_err = 0;
    if (corrupt) frm[n/2] = frm[n/2] ^ 8'h10;
    head();
    for (int i = 0; i < n; i++) begin
      send(frm[i], 1'b0, 1'b1);
      if (!(wr_en && wr_data == frm[i])) wr_err++;
      if (da_stb != (i < 6) || sa_stb != (i >= 6 && i < 12) || lt_stb != (i == 12 || i == 13))
        stb_err++;
    end
    chk(wr_err == 0, "R3 frame bytes written", wr_err, 0);
    chk(stb_err == 0, "R4 field strobes", stb_err, 0);
    chk(dst_bcast == (da == '1), "R5 broadcast flag", int'(dst_bcast), int'(da == '1));
    chk(dst_group == da[40], "R5 group flag", int'(dst_group), int'(da[40]));
    chk(int'(lt_kind) == lt_class(lt), "R6 length/type class", int'(lt_kind), lt_class(lt));
    send(term, 1'b1, 1'b1);
    exp_good = !corrupt && n >= 64 && n <= 1518;
    chk(frame_end == 1'b1, "R7 end pulse", int'(frame_end), 1);
    chk(frame_good == exp_good, "R8/R9 frame status", int'(frame_good), int'(exp_good));
    send(8'h00, 1'b0, 1'b0);
    chk(frame_end == 1'b0, "R7 end pulse one cycle", int'(frame_end), 0);
  endtask

  initial begin
    int w0, e0, n;
    logic [47:0] da;
    logic [15:0] lt;
    void'($urandom(SEED));
    repeat (3) @(posedge clk);
    #1;
    chk({wr_en, da_stb, sa_stb, lt_stb, frame_end, frame_good, dst_bcast, dst_group, lt_kind} == '0,
        "R1 reset outputs", int'(wr_en), 0);
    @(negedge clk); rst = 1'b0;
    send(8'h00, 1'b0, 1'b0);
    chk(!wr_en && !frame_end && lt_kind == 2'd0, "R1 after reset", int'(wr_en), 0);

    // length limits (R9)
    build(64, 48'h0200_0000_0001, 16'h0800);   run_frame(64, 8'hFD, 0, 48'h0200_0000_0001, 16'h0800);
    build(63, 48'h0200_0000_0001, 16'h0800);   run_frame(63, 8'hFD, 0, 48'h0200_0000_0001, 16'h0800);
    build(1518, 48'h0200_0000_0002, 16'd1500); run_frame(1518, 8'hFD, 0, 48'h0200_0000_0002, 16'd1500);
    build(1519, 48'h0200_0000_0002, 16'h86DD); run_frame(1519, 8'hFD, 0, 48'h0200_0000_0002, 16'h86DD);
    // bad FCS (R8), broadcast and group (R5), in-between values (R6), /R/ end (R7)
    build(80, 48'hFFFF_FFFF_FFFF, 16'd1501); run_frame(80, 8'hFD, 1, 48'hFFFF_FFFF_FFFF, 16'd1501);
    build(70, 48'h0100_5E00_0001, 16'h05FF); run_frame(70, 8'hF7, 0, 48'h0100_5E00_0001, 16'h05FF);
    build(70, 48'hFFFF_FFFF_FFFE, 16'h0600); run_frame(70, 8'hFD, 0, 48'hFFFF_FFFF_FFFE, 16'h0600);

    // R11: carrier extension after an end, other idle bytes
    w0 = wr_seen; e0 = end_seen;
    send(8'hF7, 1'b1, 1'b1); send(8'hF7, 1'b1, 1'b1); send(8'hFD, 1'b1, 1'b1); send(8'h42, 1'b0, 1'b1);
    chk(wr_seen == w0 && end_seen == e0, "R11 idle bytes ignored", wr_seen - w0 + end_seen - e0, 0);

    // R2: wrong preamble byte drops the packet
    w0 = wr_seen; e0 = end_seen;
    send(8'hFB, 1'b1, 1'b1); send(8'h55, 1'b0, 1'b1); send(8'h33, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) send(8'hD5, 1'b0, 1'b1);
    send(8'hFD, 1'b1, 1'b1);
    chk(wr_seen == w0 && end_seen == e0, "R2 preamble abort", wr_seen - w0 + end_seen - e0, 0);
    // R2: control byte in preamble
    w0 = wr_seen;
    send(8'hFB, 1'b1, 1'b1); send(8'hBC, 1'b1, 1'b1); send(8'hD5, 1'b0, 1'b1); send(8'h11, 1'b0, 1'b1);
    chk(wr_seen == w0, "R2 control in preamble", wr_seen - w0, 0);

    // R10: stray control byte mid-frame
    build(64, 48'h0200_0000_0003, 16'h0800);
    head();
    for (int i = 0; i < 20; i++) send(frm[i], 1'b0, 1'b1);
    send(8'hBC, 1'b1, 1'b1);
    chk(frame_end && !frame_good, "R10 control mid-frame", int'(frame_good), 0);
    w0 = wr_seen;
    for (int i = 20; i < 30; i++) send(frm[i], 1'b0, 1'b1);
    chk(wr_seen == w0, "R10 no write after abort", wr_seen - w0, 0);
    // R10: valid drop mid-frame
    head();
    for (int i = 0; i < 30; i++) send(frm[i], 1'b0, 1'b1);
    send(8'h00, 1'b0, 1'b0);
    chk(frame_end && !frame_good, "R10 data loss mid-frame", int'(frame_good), 0);
    w0 = wr_seen;
    for (int i = 30; i < 40; i++) send(frm[i], 1'b0, 1'b1);
    chk(wr_seen == w0, "R10 idle after loss", wr_seen - w0, 0);

    // random frames
    for (int f = 0; f < 24; f++) begin
      n = 64 + int'($urandom % 240);
      da = {$urandom, $urandom} ;
      if ($urandom % 4 == 0) da = '1;
      case ($urandom % 5)
        0: lt = 16'h0800;
        1: lt = 16'($urandom % 1501);
        2: lt = 16'd1501 + 16'($urandom % 35);
        default: lt = 16'($urandom);
      endcase
      build(n, da, lt);
      run_frame(n, ($urandom % 3 == 0) ? 8'hF7 : 8'hFD, ($urandom % 5 == 0), da, lt);
      if ($urandom % 2 == 0) send(8'hF7, 1'b1, 1'b1);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule